// File: doc/BRIEF.md
# Controlled Right Shifter with Status Flags

This unit executes a right-shift operation for a controller-style processor. It takes a 16-bit data word, or a 32-bit double word built from two input words, and shifts it right by a count held in a 16-bit control word. The same control word chooses whether vacated upper positions receive zeros or copies of the operand's original top bit. After each execution the unit returns the shifted value, a carry bit holding the last bit that left the low end, and three status flags: error, equals and negative.

Execution is requested by an enable input. In level mode the operation runs on every clock in which enable is high. In edge mode it runs once, in the first cycle enable is seen high after having been low. A falling enable never triggers anything. Results and flags live in registers and change only when an execution happens.

A control word that fails validation sets the error flag and leaves the result, carry, equals and negative registers as they were.

Top module: `rshift_unit`

## Requirements
- R1: Control word layout is fill code in bits 15..12, reserved bits 11..8 and count in bits 7..0. The word is invalid when the reserved bits are nonzero, when the fill code is neither 0x0 nor 0x8, or when the count exceeds 16 (single mode) or 32 (double mode). An invalid execution sets err and leaves res_lo, res_hi, carry, eq and neg unchanged.
- R2: Fill code 0x0 places zeros in every vacated bit.
- R3: Fill code 0x8 places the operand's original most significant bit (bit 15 in single mode, bit 31 in double mode) in every vacated bit.
- R4: carry takes the last bit shifted out of the low end, which is operand bit (count-1); a count of zero returns the operand unchanged and clears carry.
- R5: eq is 1 after a valid execution whose result is all zeros, else 0.
- R6: neg is 1 after a valid execution whose result has its top bit set: bit 15 in single mode, bit 31 in double mode.
- R7: With dword=1 the operand is {data_hi, data_lo} and the result appears on {res_hi, res_lo}; with dword=0 the operand is data_lo, the result is on res_lo and res_hi is written with zero.
- R8: With edge_mode=0 an execution happens on every rising clock at which enable is 1; with enable at 0 no output changes.
- R9: With edge_mode=1 an execution happens only at a clock where enable is 1 and was 0 at the previous clock; holding enable high or lowering it changes nothing.
- R10: While reset is asserted all outputs are zero.
- R11: A valid execution clears err.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| enable | input | 1 | Execution request |
| edge_mode | input | 1 | 0: run every enabled cycle, 1: run on enable rising edge only |
| dword | input | 1 | 1: 32-bit operand, 0: 16-bit operand |
| data_lo | input | 16 | Operand low word (whole operand in single mode) |
| data_hi | input | 16 | Operand high word |
| ctrl | input | 16 | Control word: fill code, reserved field, shift count |
| res_lo | output | 16 | Result low word |
| res_hi | output | 16 | Result high word |
| carry | output | 1 | Last bit shifted out |
| err | output | 1 | Control word was invalid |
| eq | output | 1 | Result is zero |
| neg | output | 1 | Result top bit is set |

## Verification
Every result and flag is due exactly one clock after the edge at which an execution is taken: inputs are applied at a falling edge, the shift and flags register at the next rising edge, and the bench compares at the falling edge after that. A behavioural model updated at each rising edge from the same inputs mirrors this single register stage, including the one-cycle memory of enable used for edge mode, so comparisons on every clock line up with the design without extra alignment. Directed phases cover the count boundaries 0, 1, 16 and 32, out-of-range counts, bad fill codes and reserved bits, and enable held high or pulsed in both trigger modes, followed by random stimulus.

// File: rtl/rshift_pkg.sv
package rshift_pkg;

  typedef enum logic [3:0] {
    FILL_ZERO = 4'h0,
    FILL_SIGN = 4'h8
  } fill_e;

  localparam int CTRL_W     = 16;
  localparam int CNT_LSB    = 0;
  localparam int CNT_MSB    = 7;
  localparam int RSV_LSB    = 8;
  localparam int RSV_MSB    = 11;
  localparam int FILL_LSB   = 12;
  localparam int FILL_MSB   = 15;

  typedef struct packed {
    logic carry;
    logic err;
    logic eq;
    logic neg;
  } flags_t;

endpackage

// File: rtl/rshift_rst_sync.sv
module rshift_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/rshift_trigger.sv
module rshift_trigger (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic edge_mode,
  output logic fire
);

  logic en_q;
  logic en_d;

  always_comb begin
    en_d = enable;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0;
    end else begin
      en_q <= en_d;
    end
  end

  always_comb begin
    if (edge_mode) begin
      fire = enable & ~en_q;
    end else begin
      fire = enable;
    end
  end

endmodule

// File: rtl/rshift_decode.sv
module rshift_decode
  import rshift_pkg::*;
#(
  parameter int W     = 16,
  parameter int CNT_W = $clog2(2 * W + 1)
) (
  input  logic [CTRL_W-1:0] ctrl,
  input  logic              dword,
  output logic [CNT_W-1:0]  cnt,
  output logic              sign_fill,
  output logic              ok
);

  localparam int RAW_W = CNT_MSB - CNT_LSB + 1;
  localparam logic [RAW_W-1:0] LIM_SINGLE = RAW_W'(W);
  localparam logic [RAW_W-1:0] LIM_DOUBLE = RAW_W'(2 * W);

  logic [RAW_W-1:0]           cnt_raw;
  logic [RSV_MSB-RSV_LSB:0]   rsv;
  logic [FILL_MSB-FILL_LSB:0] fill_code;
  logic                       fill_known;
  logic                       cnt_in_range;

  always_comb begin
    cnt_raw      = ctrl[CNT_MSB:CNT_LSB];
    rsv          = ctrl[RSV_MSB:RSV_LSB];
    fill_code    = ctrl[FILL_MSB:FILL_LSB];
    fill_known   = (fill_code == FILL_ZERO) || (fill_code == FILL_SIGN);
    cnt_in_range = dword ? (cnt_raw <= LIM_DOUBLE) : (cnt_raw <= LIM_SINGLE);
    ok           = fill_known && (rsv == '0) && cnt_in_range;
    sign_fill    = (fill_code == FILL_SIGN);
    cnt          = cnt_raw[CNT_W-1:0];
  end

endmodule

// File: rtl/rshift_core.sv
module rshift_core #(
  parameter int W     = 16,
  parameter int CNT_W = $clog2(2 * W + 1)
) (
  input  logic [2*W-1:0]  value,
  input  logic            dword,
  input  logic            sign_fill,
  input  logic [CNT_W-1:0] cnt,
  output logic [2*W-1:0]  res,
  output logic            carry_out
);

  localparam int DW = 2 * W;

  logic           fill_bit;
  logic [DW-1:0]  src;
  logic [DW:0]    stage [0:CNT_W];

  always_comb begin
    fill_bit = sign_fill & (dword ? value[DW-1] : value[W-1]);
    if (dword) begin
      src = value;
    end else begin
      src = {{W{fill_bit}}, value[W-1:0]};
    end
    stage[0] = {src, 1'b0};
  end

  for (genvar k = 0; k < CNT_W; k++) begin : g_stage
    localparam int S = 1 << k;
    always_comb begin
      if (cnt[k]) begin
        stage[k+1] = {{S{fill_bit}}, stage[k][DW:S]};
      end else begin
        stage[k+1] = stage[k];
      end
    end
  end

  always_comb begin
    carry_out = stage[CNT_W][0];
    if (dword) begin
      res = stage[CNT_W][DW:1];
    end else begin
      res = {{W{1'b0}}, stage[CNT_W][W:1]};
    end
  end

endmodule

// File: rtl/rshift_unit.sv
module rshift_unit
  import rshift_pkg::*;
#(
  parameter int W     = 16,
  parameter int CNT_W = $clog2(2 * W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              edge_mode,
  input  logic              dword,
  input  logic [W-1:0]      data_lo,
  input  logic [W-1:0]      data_hi,
  input  logic [CTRL_W-1:0] ctrl,
  output logic [W-1:0]      res_lo,
  output logic [W-1:0]      res_hi,
  output logic              carry,
  output logic              err,
  output logic              eq,
  output logic              neg
);

  localparam int DW = 2 * W;

  logic             rst_sync_n;
  logic             fire;
  logic             ctrl_ok;
  logic             sign_fill;
  logic [CNT_W-1:0] cnt;
  logic [DW-1:0]    core_res;
  logic             core_carry;

  logic [DW-1:0]    res_q, res_d;
  flags_t           flg_q, flg_d;

  rshift_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  rshift_trigger u_trig (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .enable    (enable),
    .edge_mode (edge_mode),
    .fire      (fire)
  );

  rshift_decode #(.W(W), .CNT_W(CNT_W)) u_dec (
    .ctrl      (ctrl),
    .dword     (dword),
    .cnt       (cnt),
    .sign_fill (sign_fill),
    .ok        (ctrl_ok)
  );

  rshift_core #(.W(W), .CNT_W(CNT_W)) u_core (
    .value     ({data_hi, data_lo}),
    .dword     (dword),
    .sign_fill (sign_fill),
    .cnt       (cnt),
    .res       (core_res),
    .carry_out (core_carry)
  );

  always_comb begin
    res_d = res_q;
    flg_d = flg_q;
    if (fire) begin
      if (ctrl_ok) begin
        res_d      = core_res;
        flg_d.carry = core_carry;
        flg_d.err   = 1'b0;
        flg_d.eq    = (core_res == '0);
        flg_d.neg   = dword ? core_res[DW-1] : core_res[W-1];
      end else begin
        flg_d.err   = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      res_q <= '0;
      flg_q <= '0;
    end else if (fire) begin
      res_q <= res_d;
      flg_q <= flg_d;
    end
  end

  assign res_lo = res_q[W-1:0];
  assign res_hi = res_q[DW-1:W];
  assign carry  = flg_q.carry;
  assign err    = flg_q.err;
  assign eq     = flg_q.eq;
  assign neg    = flg_q.neg;

endmodule

// File: rtl/rshift_checker.sv
module rshift_checker #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_sync_n,
  input logic         fire,
  input logic         ctrl_ok,
  input logic         enable,
  input logic         edge_mode,
  input logic         dword,
  input logic [W-1:0] data_lo,
  input logic [W-1:0] data_hi,
  input logic [15:0]  ctrl,
  input logic [W-1:0] res_lo,
  input logic [W-1:0] res_hi,
  input logic         carry,
  input logic         err,
  input logic         eq,
  input logic         neg
);

  assert_bad_ctrl_holds_R1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (fire && !ctrl_ok) |=> (err && $stable(res_lo) && $stable(res_hi) && $stable(carry)
                            && $stable(eq) && $stable(neg)));

  assert_zero_count_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (fire && ctrl_ok && ctrl[7:0] == 8'd0 && dword) |=>
      (!carry && res_lo == $past(data_lo) && res_hi == $past(data_hi)));

  assert_eq_flag_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (fire && ctrl_ok) |=> (eq == (res_lo == '0 && res_hi == '0)));

  assert_neg_flag_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (fire && ctrl_ok) |=> (neg == ($past(dword) ? res_hi[W-1] : res_lo[W-1])));

  assert_single_high_clear_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (fire && ctrl_ok && !dword) |=> (res_hi == '0));

  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!enable) |=> ($stable(res_lo) && $stable(res_hi) && $stable(carry) && $stable(err)
                   && $stable(eq) && $stable(neg)));

  assert_edge_once_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (enable) |=> !(fire && edge_mode));

  assert_err_clear_R11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (fire && ctrl_ok) |=> !err);

endmodule

bind rshift_unit rshift_checker #(.W(W)) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .fire       (fire),
  .ctrl_ok    (ctrl_ok),
  .enable     (enable),
  .edge_mode  (edge_mode),
  .dword      (dword),
  .data_lo    (data_lo),
  .data_hi    (data_hi),
  .ctrl       (ctrl),
  .res_lo     (res_lo),
  .res_hi     (res_hi),
  .carry      (carry),
  .err        (err),
  .eq         (eq),
  .neg        (neg)
);

// File: tb/tb_rshift_unit.sv
module tb_rshift_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic        edge_mode = 1'b0;
  logic        dword = 1'b0;
  logic [15:0] data_lo = '0;
  logic [15:0] data_hi = '0;
  logic [15:0] ctrl = '0;
  logic [15:0] res_lo, res_hi;
  logic        carry, err, eq, neg;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit compare_on = 1'b0;
  string phase = "R10";

  longint unsigned m_res = 0;
  bit m_c = 0, m_err = 0, m_eq = 0, m_neg = 0, m_prev = 0;

  always #2 clk = ~clk;

  rshift_unit dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .edge_mode(edge_mode), .dword(dword),
    .data_lo(data_lo), .data_hi(data_hi), .ctrl(ctrl),
    .res_lo(res_lo), .res_hi(res_hi), .carry(carry), .err(err), .eq(eq), .neg(neg)
  );

  task automatic check(input string req, input longint unsigned act, input longint unsigned exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s phase %s: actual %0h expected %0h", req, phase, act, exp);
    end
  endtask

  // Behavioural reference: one register stage, enable history for edge mode
  always @(posedge clk) begin
    if (!rst_n) begin
      m_res = 0; m_c = 0; m_err = 0; m_eq = 0; m_neg = 0; m_prev = 0;
    end else begin
      bit go;
      go = edge_mode ? (enable && !m_prev) : enable;
      m_prev = enable;
      if (go) begin
        int n, w;
        bit ok;
        longint unsigned v, r, msk;
        n = int'(ctrl[7:0]);
        w = dword ? 32 : 16;
        ok = (ctrl[11:8] == 0) && (ctrl[15:12] == 4'h0 || ctrl[15:12] == 4'h8) && (n <= w);
        if (ok) begin
          v   = dword ? {32'd0, data_hi, data_lo} : {48'd0, data_lo};
          msk = (64'd1 << w) - 1;
          if (n == 0) begin
            r = v; m_c = 0;
          end else begin
            m_c = bit'((v >> (n - 1)) & 1);
            r = v >> n;
            if (ctrl[15:12] == 4'h8 && ((v >> (w - 1)) & 1) == 1) r = r | (msk & ~(msk >> n));
          end
          m_res = r; m_err = 0; m_eq = (r == 0); m_neg = bit'((r >> (w - 1)) & 1);
        end else begin
          m_err = 1;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (compare_on) begin
      check({"R7 result ", phase}, {res_hi, res_lo}, m_res[31:0]);
      check({"R4 carry ", phase}, carry, m_c);
      check({"R1 err ", phase}, err, m_err);
      check({"R5 eq ", phase}, eq, m_eq);
      check({"R6 neg ", phase}, neg, m_neg);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic step(input bit en, input bit em, input bit dw,
                      input logic [15:0] lo, input logic [15:0] hi, input logic [15:0] c);
    @(negedge clk);
    #1;
    enable = en; edge_mode = em; dword = dw; data_lo = lo; data_hi = hi; ctrl = c;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    phase = "R10";
    check("R10 reset res", {res_hi, res_lo}, 0);
    check("R10 reset flags", {carry, err, eq, neg}, 0);
    #1 rst_n = 1'b1;
    repeat (4) @(negedge clk);
    compare_on = 1'b1;

    phase = "R2";
    step(1, 0, 0, 16'hB6A5, 0, 16'h0000);
    step(1, 0, 0, 16'hB6A5, 0, 16'h0001);
    step(1, 0, 0, 16'hB6A5, 0, 16'h0005);
    step(1, 0, 0, 16'hB6A5, 0, 16'h000F);
    step(1, 0, 0, 16'hB6A5, 0, 16'h0010);
    phase = "R3";
    step(1, 0, 0, 16'hB6A5, 0, 16'h800A);
    step(1, 0, 0, 16'h36A5, 0, 16'h800A);
    step(1, 0, 0, 16'h8000, 0, 16'h8010);
    phase = "R7";
    step(1, 0, 1, 16'h1234, 16'h9ABC, 16'h0000);
    step(1, 0, 1, 16'h1234, 16'h9ABC, 16'h0001);
    step(1, 0, 1, 16'h1234, 16'h9ABC, 16'h8011);
    step(1, 0, 1, 16'h1234, 16'h9ABC, 16'h001F);
    step(1, 0, 1, 16'h1234, 16'h9ABC, 16'h8020);
    step(1, 0, 1, 16'h1234, 16'h9ABC, 16'h0020);
    phase = "R5";
    step(1, 0, 0, 16'h0000, 0, 16'h0003);
    step(1, 0, 0, 16'h0001, 0, 16'h0001);
    phase = "R1";
    step(1, 0, 0, 16'hFFFF, 0, 16'h0011);
    step(1, 0, 0, 16'hFFFF, 0, 16'h0102);
    step(1, 0, 0, 16'hFFFF, 0, 16'h4002);
    step(1, 0, 1, 16'hFFFF, 16'hFFFF, 16'h0021);
    phase = "R11";
    step(1, 0, 0, 16'hC001, 0, 16'h0002);
    phase = "R8";
    step(0, 0, 0, 16'h5555, 0, 16'h0001);
    step(0, 0, 1, 16'hAAAA, 16'h1111, 16'h0004);
    step(1, 0, 0, 16'h00F0, 0, 16'h0004);
    step(1, 0, 0, 16'h0F00, 0, 16'h0004);
    phase = "R9";
    step(0, 1, 0, 16'h0F00, 0, 16'h0004);
    step(1, 1, 0, 16'hF000, 0, 16'h0004);
    step(1, 1, 0, 16'h00FF, 0, 16'h0001);
    step(1, 1, 0, 16'h0000, 0, 16'h0000);
    step(0, 1, 0, 16'h1234, 0, 16'h0000);
    step(1, 1, 1, 16'h1234, 16'h8000, 16'h8008);
    step(0, 1, 0, 16'h1234, 0, 16'h0000);

    phase = "random";
    for (int i = 0; i < 400; i++) begin
      logic [15:0] c;
      c = {($urandom_range(0, 7) == 0) ? 4'($urandom) : (($urandom & 1) ? 4'h8 : 4'h0),
           ($urandom_range(0, 9) == 0) ? 4'($urandom) : 4'h0,
           8'($urandom_range(0, 34))};
      step(1'($urandom_range(0, 3) != 0), 1'($urandom), 1'($urandom),
           16'($urandom), 16'($urandom), c);
    end
    step(0, 0, 0, 0, 0, 0);
    @(negedge clk);
    compare_on = 1'b0;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule